// File: doc/BRIEF.md
# Saturating Extended-Dividend Integer Divider

This block performs integer division for a 64-bit register machine over several cycles. In its 32-bit modes the dividend is 64 bits wide. Its upper half comes from a separate 32-bit Y input and its lower half from the low 32 bits of the first operand. The divisor is the low 32 bits of the second operand. A 32-bit quotient that does not fit is clamped to a fixed saturation value; it never wraps. In its 64-bit modes the block divides the full first operand by the full second operand. Y is not used in those modes and no clamping takes place.

An issuing pipeline pulses `start` with the operands and an operation select, then waits for `done`. A zero divisor is detected at issue. In that case the block raises a fault alongside `done` and leaves the destination value untouched. The trap logic acts on that fault. Operations flagged as condition-code variants also report on `ov_flag` whether clamping occurred.

Top module: `sat_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `ov_flag` and `result` are all zero.
- R2: A `start` sampled while `busy` is low, with a nonzero divisor, makes `busy` high for the next 65 cycles. Then `done` is high for exactly one cycle with `busy` low, and `result` carries the quotient.
- R3: A `start` sampled while `busy` is high is ignored. The operation in flight completes at its own time with its own result.
- R4: If the divisor is zero (the low 32 bits of `rs2` in 32-bit modes, all 64 bits in 64-bit modes), `done` and `div_zero` are high together in the cycle after `start`. `busy` stays low, `result` keeps its previous value, and `ov_flag` becomes 0.
- R5: In 32-bit modes the dividend is {`y_in`, `rs1[31:0]`}. An unsigned 32-bit quotient that fits is returned zero-extended to 64 bits.
- R6: Unsigned 32-bit division whose quotient has any bit set above bit 31 returns 0x00000000FFFFFFFF.
- R7: Signed 32-bit division whose quotient exceeds 0x7FFFFFFF returns 0x000000007FFFFFFF.
- R8: Signed 32-bit division whose quotient is below -2^31 returns 0xFFFFFFFF80000000. A quotient of exactly -2^31 is returned as is.
- R9: Signed division truncates toward zero. A signed 32-bit quotient that fits is returned sign-extended to 64 bits.
- R10: 64-bit modes ignore `y_in` and never clamp. Signed -2^63 divided by -1 returns 0x8000000000000000.
- R11: `ov_flag` is updated only when `done` is high. It is set when a condition-code variant clamped its quotient and is cleared otherwise. It holds between completions.
- R12: `op_sel[1:0]` selects the mode: 0 unsigned 32-bit, 1 signed 32-bit, 2 unsigned 64-bit, 3 signed 64-bit. `op_sel[2]` = 1 marks the condition-code variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue request, one cycle |
| op_sel | input | 3 | Mode and condition-code variant select |
| y_in | input | 32 | Upper dividend half for 32-bit modes |
| rs1 | input | 64 | Dividend (low half only in 32-bit modes) |
| rs2 | input | 64 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient, held until the next completion |
| div_zero | output | 1 | Division-by-zero fault, with `done` |
| ov_flag | output | 1 | Overflow flag for condition-code variants |

## Verification
The bench targets the clamp boundaries. Quotients just inside and just outside the signed 32-bit range are used; a design that compared against the wrong limit would clamp -2^31 or would let 2^32 wrap. Divisors whose low half is zero but whose upper half is not are used in 32-bit mode. A design that tested the full operand would start a division instead of faulting. Negative operands with remainders are divided; a floor divider would return results that are off by one. A second start arriving mid-operation is also exercised, and a design that reloaded on it would finish late with the wrong quotient.

// File: rtl/sat_divider_pkg.sv
// Shared types for the saturating divider.
package sat_divider_pkg;
    typedef enum logic [1:0] {
        K_UDIV32 = 2'd0,
        K_SDIV32 = 2'd1,
        K_UDIV64 = 2'd2,
        K_SDIV64 = 2'd3
    } div_kind_e;
endpackage

// File: rtl/div_operand_prep.sv
// Forms the dividend and divisor for the selected mode and reduces them to
// magnitudes. Also gives the quotient sign and flags a zero divisor.
// Assumes XLEN is even; 32-bit modes use the low XLEN/2 bits.
module div_operand_prep
    import sat_divider_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  div_kind_e            kind,
    input  logic [XLEN/2-1:0]    y_half,
    input  logic [XLEN-1:0]      opa,
    input  logic [XLEN-1:0]      opb,
    output logic [XLEN-1:0]      dvd_mag,
    output logic [XLEN-1:0]      dvs_mag,
    output logic                 q_neg,
    output logic                 dvs_zero
);
    localparam int HALF = XLEN / 2;

    logic            narrow, signed_op, dvd_neg, dvs_neg;
    logic [XLEN-1:0] dvd_raw, dvs_raw;

    // Build raw operands, take magnitudes and derive the quotient sign
    always_comb begin
        narrow    = (kind == K_UDIV32) || (kind == K_SDIV32);
        signed_op = (kind == K_SDIV32) || (kind == K_SDIV64);
        dvd_raw   = narrow ? {y_half, opa[HALF-1:0]} : opa;
        if (!narrow)
            dvs_raw = opb;
        else if (signed_op)
            dvs_raw = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
        else
            dvs_raw = {{HALF{1'b0}}, opb[HALF-1:0]};
        dvd_neg  = signed_op & dvd_raw[XLEN-1];
        dvs_neg  = signed_op & dvs_raw[XLEN-1];
        dvd_mag  = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
        dvs_mag  = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
        q_neg    = dvd_neg ^ dvs_neg;
        dvs_zero = (dvs_raw == '0);
    end
endmodule

// File: rtl/div_iter_core.sv
// Unsigned radix-2 restoring divider producing one quotient bit per cycle.
// After load it runs XLEN iterations, then raises fin for one cycle.
// Assumes the divisor is nonzero.
module div_iter_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] quo,
    output logic            fin
);
    localparam int CW = $clog2(XLEN + 1);

    logic [XLEN-1:0] rem, dvs_r;
    logic [CW-1:0]   cnt;
    logic            running;
    logic [XLEN:0]   part, diff;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        part = {rem, quo[XLEN-1]};
        diff = part - {1'b0, dvs_r};
    end

    assign fin = running && (cnt == '0);

    // Load operands, then iterate until the counter runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem     <= '0;
            quo     <= '0;
            dvs_r   <= '0;
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            rem     <= '0;
            quo     <= dvd;
            dvs_r   <= dvs;
            cnt     <= CW'(XLEN);
            running <= 1'b1;
        end else if (running && cnt != '0) begin
            if (!diff[XLEN]) begin
                rem <= diff[XLEN-1:0];
                quo <= {quo[XLEN-2:0], 1'b1};
            end else begin
                rem <= part[XLEN-1:0];
                quo <= {quo[XLEN-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
        end else if (fin) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/div_result_fix.sv
// Restores the quotient sign and clamps 32-bit quotients that do not fit.
// Reports whether clamping happened. Assumes quo is a magnitude.
module div_result_fix
    import sat_divider_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  div_kind_e        kind,
    input  logic             q_neg,
    input  logic [XLEN-1:0]  quo,
    output logic [XLEN-1:0]  res,
    output logic             sat
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] POS_LIM = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
    localparam logic [XLEN-1:0] NEG_MAG = {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};
    localparam logic [XLEN-1:0] NEG_SAT = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
    localparam logic [XLEN-1:0] U_SAT   = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic [XLEN-1:0] signed_q;

    // Apply sign, then select clamp or pass-through per mode
    always_comb begin
        signed_q = q_neg ? (~quo + 1'b1) : quo;
        sat      = 1'b0;
        res      = quo;
        unique case (kind)
            K_UDIV32: begin
                if (quo[XLEN-1:HALF] != '0) begin
                    res = U_SAT;
                    sat = 1'b1;
                end else begin
                    res = {{HALF{1'b0}}, quo[HALF-1:0]};
                end
            end
            K_SDIV32: begin
                if (!q_neg && quo > POS_LIM) begin
                    res = POS_LIM;
                    sat = 1'b1;
                end else if (q_neg && quo > NEG_MAG) begin
                    res = NEG_SAT;
                    sat = 1'b1;
                end else begin
                    res = signed_q;
                end
            end
            K_UDIV64: res = quo;
            K_SDIV64: res = signed_q;
            default:  res = quo;
        endcase
    end
endmodule

// File: rtl/sat_divider.sv
// Top of the saturating divider. Accepts a request when idle and faults at
// once on a zero divisor. Otherwise it runs the iterative core and registers
// the fixed-up quotient and overflow flag on completion.
// Assumes start is a single-cycle request; starts while busy are dropped.
module sat_divider
    import sat_divider_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_sel,
    input  logic [XLEN/2-1:0] y_in,
    input  logic [XLEN-1:0]   rs1,
    input  logic [XLEN-1:0]   rs2,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   result,
    output logic              div_zero,
    output logic              ov_flag
);
    div_kind_e       kind_in, kind_r;
    logic            cc_r, qneg_r;
    logic [XLEN-1:0] dvd_mag, dvs_mag, quo, fixed;
    logic            q_neg, dvs_zero, fin, sat, accept, load;

    assign kind_in = div_kind_e'(op_sel[1:0]);
    assign accept  = start && !busy;
    assign load    = accept && !dvs_zero;

    div_operand_prep #(.XLEN(XLEN)) prep_i (
        .kind(kind_in), .y_half(y_in), .opa(rs1), .opb(rs2),
        .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .q_neg(q_neg), .dvs_zero(dvs_zero)
    );

    div_iter_core #(.XLEN(XLEN)) core_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .dvd(dvd_mag), .dvs(dvs_mag), .quo(quo), .fin(fin)
    );

    div_result_fix #(.XLEN(XLEN)) fix_i (
        .kind(kind_r), .q_neg(qneg_r), .quo(quo), .res(fixed), .sat(sat)
    );

    // Request acceptance, fault path and completion capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            ov_flag  <= 1'b0;
            result   <= '0;
            kind_r   <= K_UDIV32;
            cc_r     <= 1'b0;
            qneg_r   <= 1'b0;
        end else begin
            done     <= 1'b0;
            div_zero <= 1'b0;
            if (busy) begin
                if (fin) begin
                    busy    <= 1'b0;
                    done    <= 1'b1;
                    result  <= fixed;
                    ov_flag <= cc_r & sat;
                end
            end else if (accept) begin
                kind_r <= kind_in;
                cc_r   <= op_sel[2];
                qneg_r <= q_neg;
                if (dvs_zero) begin
                    done     <= 1'b1;
                    div_zero <= 1'b1;
                    ov_flag  <= 1'b0;
                end else begin
                    busy <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sat_divider_chk.sv
// Protocol and output checks for sat_divider, attached by bind.
module sat_divider_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            div_zero,
    input logic            ov_flag
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] U_SAT   = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam logic [XLEN-1:0] POS_SAT = {{(HALF+1){1'b0}}, {(HALF-1){1'b1}}};
    localparam logic [XLEN-1:0] NEG_SAT = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};

    // R2: completion pulse never overlaps an operation in flight
    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R2: a running operation either continues or completes
    a_r2_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));
    // R2: busy falls only together with done
    a_r2_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R4: the fault comes only as a completion
    a_r4_zero_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done);
    // R4: a faulting request leaves the destination untouched
    a_r4_zero_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> $stable(result));
    // R2: result changes only when an operation completes
    a_r2_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    // R11: the overflow flag changes only on completion
    a_r11_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ov_flag));
    // R6: a set overflow flag always comes with a clamp value
    a_r6_flag_means_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |-> (result == U_SAT || result == POS_SAT || result == NEG_SAT));
endmodule

bind sat_divider sat_divider_chk #(.XLEN(XLEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .result(result), .div_zero(div_zero), .ov_flag(ov_flag)
);

// File: tb/sat_divider_tb_top.sv
module sat_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] y_in = '0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic        busy, done, div_zero, ov_flag;
    logic [63:0] result;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    // reference model state
    bit          m_busy, m_done, m_dz, m_v, p_v;
    int          m_cnt;
    logic [63:0] m_res, p_res;

    always #2 clk = ~clk;

    sat_divider dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .y_in(y_in), .rs1(rs1), .rs2(rs2), .busy(busy), .done(done),
        .result(result), .div_zero(div_zero), .ov_flag(ov_flag)
    );

    function automatic void ref_div(input logic [2:0] op, input logic [31:0] y,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output bit v, output bit z);
        logic signed [127:0] sn, sd, sq;
        logic [127:0] un, ud, uq;
        bit sat = 0;
        r = '0;
        z = 0;
        case (op[1:0])
            2'd0: begin
                un = {64'd0, y, a[31:0]};
                ud = {96'd0, b[31:0]};
                z = (b[31:0] == 0);
                if (!z) begin
                    uq = un / ud;
                    if (uq[127:32] != 0) begin r = 64'h0000_0000_FFFF_FFFF; sat = 1; end
                    else r = uq[63:0];
                end
            end
            2'd1: begin
                sn = 128'($signed({y, a[31:0]}));
                sd = 128'($signed(b[31:0]));
                z = (b[31:0] == 0);
                if (!z) begin
                    sq = sn / sd;
                    if (sq > 128'sd2147483647) begin r = 64'h0000_0000_7FFF_FFFF; sat = 1; end
                    else if (sq < -128'sd2147483648) begin r = 64'hFFFF_FFFF_8000_0000; sat = 1; end
                    else r = sq[63:0];
                end
            end
            2'd2: begin
                z = (b == 0);
                if (!z) r = a / b;
            end
            default: begin
                z = (b == 0);
                if (!z) begin
                    sn = 128'($signed(a));
                    sd = 128'($signed(b));
                    sq = sn / sd;
                    r = sq[63:0];
                end
            end
        endcase
        v = op[2] && sat;
    endfunction

    // Cycle-level reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_v = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0;
            m_dz = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_res = p_res; m_v = p_v;
                end
            end else if (start) begin
                bit z;
                ref_div(op_sel, y_in, rs1, rs2, p_res, p_v, z);
                if (z) begin m_done = 1; m_dz = 1; m_v = 0; end
                else begin m_busy = 1; m_cnt = 65; end
            end
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("busy", 64'(busy), 64'(m_busy));
            chk("done", 64'(done), 64'(m_done));
            chk("div_zero", 64'(div_zero), 64'(m_dz));
            chk("ov_flag", 64'(ov_flag), 64'(m_v));
            chk("result", result, m_res);
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic issue(input string req, input logic [2:0] op, input logic [31:0] y,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        cur_req = req;
        op_sel = op; y_in = y; rs1 = a; rs2 = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        y_in = 32'hDEAD_BEEF; rs1 = '1; rs2 = '1;
        repeat (70) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        cur_req = "R1";
        chk("busy", 64'(busy), 0);
        chk("done", 64'(done), 0);
        chk("div_zero", 64'(div_zero), 0);
        chk("ov_flag", 64'(ov_flag), 0);
        chk("result", result, 0);
        rst_n = 1'b1;

        // R5 R12 R2: plain unsigned 32-bit, then the Y half in the dividend
        issue("R5", 3'd0, 32'd0, 64'hFFFF_FFFF_0000_0064, 64'd7);
        issue("R5", 3'd0, 32'd1, 64'd0, 64'd2);
        // R6 R11: unsigned clamp, plain and with flag
        issue("R6", 3'd0, 32'd5, 64'd0, 64'd2);
        issue("R11", 3'd4, 32'd5, 64'd0, 64'd2);
        issue("R11", 3'd4, 32'd0, 64'd50, 64'd5);
        // R9: signed truncation toward zero, sign-extended
        issue("R9", 3'd1, 32'hFFFF_FFFF, 64'hFFFF_FFF9, 64'd2);
        issue("R9", 3'd1, 32'd0, 64'd7, 64'hFFFF_FFFE);
        // R7: positive clamp with flag
        issue("R7", 3'd5, 32'd1, 64'd0, 64'd1);
        // R8: negative clamp with flag, then the exact lower bound
        issue("R8", 3'd5, 32'hFFFF_FFFF, 64'd0, 64'd1);
        issue("R8", 3'd5, 32'hFFFF_FFFF, 64'h8000_0000, 64'd1);
        // R10: 64-bit modes ignore Y and never clamp
        issue("R10", 3'd6, 32'hFFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 64'd3);
        issue("R10", 3'd7, 32'h7, 64'hFFFF_FFFF_FFFF_FF00, 64'd16);
        issue("R10", 3'd7, 32'h0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        // R4: zero low half in 32-bit mode, zero in 64-bit mode
        issue("R4", 3'd4, 32'd1, 64'd9, 64'hFFFF_0000_0000);
        issue("R4", 3'd2, 32'd1, 64'd9, 64'd0);

        // R3: a second start mid-operation is dropped
        @(negedge clk);
        cur_req = "R3";
        op_sel = 3'd2; rs1 = 64'd1000; rs2 = 64'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        op_sel = 3'd2; rs1 = 64'd77; rs2 = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);
        chk("result after dropped start", result, 64'd100);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule